// File: doc/BRIEF.md
# Dynamic Memory Refresh Scheduler

This block decides when each row of a dynamic memory array gets refreshed. It also arbitrates those refreshes against host read and write accesses. A free-running timer marks boundaries. A row counter names the next row to refresh. A small engine issues one refresh command per row and holds it for a fixed number of cycles. The nominal clock is 50 MHz. With that clock the default parameters give a 64 ms window, 4096 rows, a 780-cycle spacing between rows and a 3-cycle refresh. Every one of these is a parameter, so a bench can shrink them.

Two refresh policies are available, chosen by `mode_burst`. In distributed mode one row is owed at every interval boundary. In burst mode every row is owed at once at each window boundary, and the rows then run back to back. A mode change is sampled only at a boundary. The row counter keeps counting across mode changes.

Host accesses use a valid/ready handshake. A transfer happens in any cycle where `host_req_valid` and `host_req_ready` are both high. After a transfer, the access is in flight until the host pulses `host_done`.

Back-pressure rules:
- `host_req_ready` is low while a refresh runs.
- It is low while any refresh is owed.
- It is low while an access is in flight.
- A host that sees ready low keeps valid high and waits.

A refresh that falls due during an in-flight access waits for `host_done`. After that, it wins against any new request.

Top module: `dram_refresh_sched`

## Requirements
- R1: During and just after reset, `host_req_ready` is 1, `ref_busy`, `ref_cmd` and `ref_done` are 0, and `ref_row` is 0.
- R2: `ref_row` changes only at the end of a refresh. It then advances by one and wraps from ROWS-1 to 0. A mode change never resets it, and the first refresh after reset uses row 0.
- R3: With `mode_burst`=0 (distributed), consecutive refresh commands are exactly INTERVAL_CYC cycles apart when no host access delays them. ROWS refreshes fit inside one WINDOW_CYC window.
- R4: With `mode_burst`=1 (burst), ROWS refreshes run back to back. `ref_cmd` pulses once per row, REF_CYC cycles apart, and `ref_busy` stays high for ROWS*REF_CYC cycles. Bursts start WINDOW_CYC cycles apart.
- R5: Each refresh holds `ref_busy` high for REF_CYC cycles. `ref_done` is a one-cycle pulse in the cycle after `ref_busy` falls, raised only when no further rows are owed. In distributed mode it follows every refresh; in a burst it follows only the last row.
- R6: No host transfer completes while `ref_busy` is high or while a refresh is owed.
- R7: A refresh owed during an in-flight access does not start until the cycle after `host_done` is seen. Rows owed meanwhile then run back to back, ahead of any new request.
- R8: `mode_burst` is sampled only at a timer boundary. That sample selects both what is owed at that boundary (one row or all rows) and the length of the next period (INTERVAL_CYC or WINDOW_CYC).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_burst | input | 1 | 1 = burst policy, 0 = distributed policy |
| host_req_valid | input | 1 | Host wants to start a read or write |
| host_req_ready | output | 1 | Host access may start this cycle |
| host_done | input | 1 | One-cycle pulse ending the in-flight access |
| ref_cmd | output | 1 | One-cycle pulse starting a row refresh |
| ref_row | output | ROW_W | Row being refreshed (valid with ref_cmd/ref_busy) |
| ref_busy | output | 1 | A refresh cycle is in progress |
| ref_done | output | 1 | One-cycle pulse: refresh work complete, nothing owed |

## Verification
The assertions assume the host follows the handshake. A host pulses `host_done` only for an access it was granted, and never in the same cycle as that grant. The bench drives each access as a single transfer and raises `host_done` only after holding the access for a number of cycles. All inputs change one nanosecond after a rising edge, and the mode input is changed only well clear of a timer boundary.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic {
    ENG_IDLE = 1'b0,
    ENG_RUN  = 1'b1
  } eng_state_t;
endpackage

// File: rtl/rs_timer.sv
// Boundary timer: period follows the mode latched at the previous boundary.
module rs_timer #(
  parameter int INTERVAL_CYC = 780,
  parameter int WINDOW_CYC   = 3_200_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_burst,
  output logic tick,
  output logic owe_all
);
  localparam int TMR_W = $clog2(WINDOW_CYC);
  localparam logic [TMR_W-1:0] WIN_LAST = TMR_W'(WINDOW_CYC - 1);
  localparam logic [TMR_W-1:0] INT_LAST = TMR_W'(INTERVAL_CYC - 1);

  logic [TMR_W-1:0] tmr;
  logic             act_burst;
  logic [TMR_W-1:0] last_val;

  always_comb begin
    last_val = act_burst ? WIN_LAST : INT_LAST;
    tick     = (tmr == last_val);
    owe_all  = tick & mode_burst;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr       <= '0;
      act_burst <= 1'b0;
    end else if (tick) begin
      tmr       <= '0;
      act_burst <= mode_burst;
    end else begin
      tmr <= tmr + 1'b1;
    end
  end
endmodule

// File: rtl/rs_engine.sv
// Owed-row bookkeeping and the refresh sequencer.
module rs_engine
  import rs_pkg::*;
#(
  parameter int ROWS    = 4096,
  parameter int REF_CYC = 3,
  localparam int ROW_W  = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             owe_all,
  input  logic             hold,
  output logic             busy,
  output logic             cmd,
  output logic [ROW_W-1:0] row,
  output logic             done,
  output logic             owed_any
);
  localparam int PEND_W = $clog2(ROWS + 1);
  localparam int CNT_W  = (REF_CYC > 1) ? $clog2(REF_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REF_CYC - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

  eng_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [PEND_W-1:0] pend, pend_nxt;
  logic [PEND_W:0]   sum;
  logic              last;

  always_comb begin
    last = (state == ENG_RUN) && (cnt == CNT_LAST);
    sum  = {1'b0, pend};
    if (tick)
      sum = sum + (owe_all ? (PEND_W+1)'(ROWS) : (PEND_W+1)'(1));
    if (last)
      sum = sum - (PEND_W+1)'(1);
    pend_nxt = (sum > (PEND_W+1)'(ROWS)) ? PEND_W'(ROWS) : sum[PEND_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ENG_IDLE;
      cnt   <= '0;
      pend  <= '0;
      row   <= '0;
      done  <= 1'b0;
    end else begin
      pend <= pend_nxt;
      done <= 1'b0;
      case (state)
        ENG_IDLE: begin
          if (pend != '0 && !hold) begin
            state <= ENG_RUN;
            cnt   <= '0;
          end
        end
        ENG_RUN: begin
          if (last) begin
            row <= (row == ROW_LAST) ? '0 : row + 1'b1;
            cnt <= '0;
            if (pend_nxt == '0) begin
              state <= ENG_IDLE;
              done  <= 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  always_comb begin
    busy     = (state == ENG_RUN);
    cmd      = busy && (cnt == '0);
    owed_any = (pend != '0);
  end
endmodule

// File: rtl/rs_host_gate.sv
// Host handshake gate: tracks one in-flight access.
module rs_host_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  input  logic host_done,
  input  logic busy,
  input  logic owed,
  output logic ready,
  output logic inflight
);
  always_comb ready = !busy && !owed && !inflight;

  always_ff @(posedge clk) begin
    if (!rst_n)
      inflight <= 1'b0;
    else if (valid && ready)
      inflight <= 1'b1;
    else if (host_done)
      inflight <= 1'b0;
  end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int ROWS         = 4096,
  parameter int INTERVAL_CYC = 780,
  parameter int WINDOW_CYC   = 3_200_000,
  parameter int REF_CYC      = 3,
  localparam int ROW_W       = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_burst,
  input  logic             host_req_valid,
  output logic             host_req_ready,
  input  logic             host_done,
  output logic             ref_cmd,
  output logic [ROW_W-1:0] ref_row,
  output logic             ref_busy,
  output logic             ref_done
);
  logic tick, owe_all, owed_any, inflight;

  rs_timer #(.INTERVAL_CYC(INTERVAL_CYC), .WINDOW_CYC(WINDOW_CYC)) timer_i (
    .clk(clk), .rst_n(rst_n), .mode_burst(mode_burst),
    .tick(tick), .owe_all(owe_all)
  );

  rs_engine #(.ROWS(ROWS), .REF_CYC(REF_CYC)) engine_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .owe_all(owe_all), .hold(inflight),
    .busy(ref_busy), .cmd(ref_cmd), .row(ref_row), .done(ref_done),
    .owed_any(owed_any)
  );

  rs_host_gate gate_i (
    .clk(clk), .rst_n(rst_n), .valid(host_req_valid), .host_done(host_done),
    .busy(ref_busy), .owed(owed_any), .ready(host_req_ready),
    .inflight(inflight)
  );
endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
  parameter int ROWS = 4096,
  localparam int ROW_W = $clog2(ROWS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_busy,
  input logic             ref_cmd,
  input logic [ROW_W-1:0] ref_row,
  input logic             ref_done,
  input logic             host_req_ready,
  input logic             inflight
);
  AST_NO_GRANT_IN_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
    ref_busy |-> !host_req_ready); // R6
  AST_CMD_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cmd |-> ref_busy); // R4
  AST_DONE_AFTER_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |-> (!ref_busy && $past(ref_busy))); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |=> !ref_done); // R5
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ref_row) |-> (ref_row == (($past(ref_row) == ROW_W'(ROWS - 1)) ? '0 : $past(ref_row) + 1'b1))); // R2
  AST_ROW_MOVES_AFTER_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ref_row) |-> $past(ref_busy)); // R2
  AST_WAIT_FOR_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_busy) |-> !$past(inflight)); // R7
endmodule

bind dram_refresh_sched rs_checker #(.ROWS(ROWS)) chk_i (
  .clk(clk), .rst_n(rst_n), .ref_busy(ref_busy), .ref_cmd(ref_cmd),
  .ref_row(ref_row), .ref_done(ref_done), .host_req_ready(host_req_ready),
  .inflight(inflight)
);

// File: tb/dram_refresh_sched_tb_top.sv
`timescale 1ns/1ps
module dram_refresh_sched_tb_top;
  localparam int ROWS = 16, INTERVAL = 24, WINDOW = 400, REFC = 3;
  localparam int RW = $clog2(ROWS);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, mode_burst = 1'b0, host_req_valid = 1'b0, host_done = 1'b0;
  logic host_req_ready, ref_cmd, ref_busy, ref_done;
  logic [RW-1:0] ref_row;

  dram_refresh_sched #(.ROWS(ROWS), .INTERVAL_CYC(INTERVAL), .WINDOW_CYC(WINDOW),
    .REF_CYC(REFC)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_burst(mode_burst),
    .host_req_valid(host_req_valid), .host_req_ready(host_req_ready),
    .host_done(host_done), .ref_cmd(ref_cmd), .ref_row(ref_row),
    .ref_busy(ref_busy), .ref_done(ref_done));

  int n_tests = 0, n_fail = 0, cyc = 0;
  int cmd_cyc[1024], cmd_row[1024], done_cyc[1024];
  int n_cmd = 0, n_done = 0, n_grant = 0, grant_cyc = 0;
  int overlap = 0, busy_run = 0, last_run = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ref_cmd && n_cmd < 1024) begin
        cmd_cyc[n_cmd] = cyc; cmd_row[n_cmd] = int'(ref_row); n_cmd++;
      end
      if (ref_done && n_done < 1024) begin done_cyc[n_done] = cyc; n_done++; end
      if (host_req_valid && host_req_ready) begin
        grant_cyc = cyc; n_grant++;
        if (ref_busy) overlap++;
      end
      if (ref_busy) busy_run++;
      else if (busy_run != 0) begin last_run = busy_run; busy_run = 0; end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wait_cmds(input int n);
    while (n_cmd < n) step();
  endtask

  task automatic wait_done_edge();
    int d0 = n_done;
    while (n_done == d0) step();
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  task automatic t_reset();
    repeat (3) step();
    chk("R1 ready", int'(host_req_ready), 1);
    chk("R1 busy", int'(ref_busy), 0);
    chk("R1 cmd", int'(ref_cmd), 0);
    chk("R1 done", int'(ref_done), 0);
    chk("R1 row", int'(ref_row), 0);
    rst_n = 1'b1;
    step();
    chk("R1 ready after release", int'(host_req_ready), 1);
  endtask

  task automatic t_distributed();
    int bad = 0, hits = 0;
    wait_cmds(ROWS + 1);
    chk("R2 first row", cmd_row[0], 0);
    for (int i = 1; i <= ROWS; i++)
      if (cmd_cyc[i] - cmd_cyc[i-1] != INTERVAL) bad++;
    chk("R3 spacing errors", bad, 0);
    chk("R3 rows fit window", int'(cmd_cyc[ROWS-1] - cmd_cyc[0] + REFC <= WINDOW), 1);
    repeat (REFC + 2) step();
    chk("R5 busy length", last_run, REFC);
    for (int i = 0; i <= ROWS; i++)
      for (int j = 0; j < n_done; j++)
        if (done_cyc[j] == cmd_cyc[i] + REFC) hits++;
    chk("R5 done after each", hits, ROWS + 1);
    chk("R5 done count", n_done, ROWS + 1);
  endtask

  task automatic t_host_hold();
    int base, hd, g0;
    wait_done_edge();
    host_req_valid = 1'b1;
    g0 = n_grant;
    step();
    host_req_valid = 1'b0;
    chk("R6 grant when idle", n_grant - g0, 1);
    base = n_cmd;
    repeat (2*INTERVAL + 2) step();
    chk("R7 no refresh in flight", n_cmd - base, 0);
    host_done = 1'b1; host_req_valid = 1'b1; hd = cyc; g0 = n_grant;
    step();
    host_done = 1'b0;
    wait_cmds(base + 2);
    chk("R7 start after host_done", cmd_cyc[base], hd + 2);
    chk("R7 owed back to back", cmd_cyc[base+1] - cmd_cyc[base], REFC);
    while (n_grant == g0) step();
    host_req_valid = 1'b0;
    chk("R6 grant after owed rows", grant_cyc, cmd_cyc[base+1] + REFC);
    step();
    host_done = 1'b1;
    step();
    host_done = 1'b0;
  endtask

  task automatic t_bursts();
    int base, bad = 0, dc = 0, dat = 0, b2;
    wait_done_edge();
    repeat (4) step();
    mode_burst = 1'b1;
    base = n_cmd;
    wait_cmds(base + ROWS);
    chk("R8 switch at boundary", cmd_cyc[base] - cmd_cyc[base-1], INTERVAL);
    chk("R2 row kept over mode change", cmd_row[base], (cmd_row[base-1] + 1) % ROWS);
    for (int i = base + 1; i < base + ROWS; i++)
      if (cmd_cyc[i] - cmd_cyc[i-1] != REFC) bad++;
    chk("R4 burst spacing errors", bad, 0);
    repeat (REFC + 2) step();
    chk("R4 busy across burst", last_run, ROWS * REFC);
    for (int j = 0; j < n_done; j++)
      if (done_cyc[j] >= cmd_cyc[base] && done_cyc[j] <= cmd_cyc[base+ROWS-1] + REFC) begin
        dc++; dat = done_cyc[j];
      end
    chk("R5 one done per burst", dc, 1);
    chk("R5 done after last row", dat, cmd_cyc[base+ROWS-1] + REFC);
    wait_cmds(base + ROWS + 1);
    chk("R4 burst period", cmd_cyc[base+ROWS] - cmd_cyc[base], WINDOW);
    step();
    mode_burst = 1'b0;
    b2 = base + ROWS;
    wait_cmds(b2 + ROWS + 2);
    chk("R8 window completes", cmd_cyc[b2+ROWS] - cmd_cyc[b2], WINDOW);
    chk("R3 distributed resumes", cmd_cyc[b2+ROWS+1] - cmd_cyc[b2+ROWS], INTERVAL);
  endtask

  task automatic t_final();
    int bad = 0;
    for (int i = 1; i < n_cmd; i++)
      if (cmd_row[i] != (cmd_row[i-1] + 1) % ROWS) bad++;
    chk("R2 row continuity and wrap", bad, 0);
    chk("R6 grants during refresh", overlap, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_distributed();
    t_host_hold();
    t_bursts();
    t_final();
    summary();
    $finish;
  end
endmodule